// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps a 32-bit bus address onto one of eight address windows. Each window has three parts: a base register, a size-mask register, and an enable bit with a two-bit access field in a shared control word. The base register holds the address in its upper half and an 8-bit target attribute in bits [15:8]. Windows 0 to 3 point at DRAM chip selects. Window 4 is an SRAM aperture at a fixed place. Windows 5 to 7 follow the DRAM base formula and carry attribute 0.

A single-cycle configuration pulse programs the windows. Its inputs are a bitmap of targets to enable, a limit on how many targets to enable, the size of one chip select, and an offset added to every DRAM base. The same pulse saves the previous control word and the registers of windows 0 to 4 into a snapshot, and a restore pulse writes them back. A separate pulse narrows window 0 so that it no longer covers the SRAM aperture.

The lookup port takes an address and a request strobe. One cycle later it returns hit or miss, the number of the winning window and that window's attribute.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, `win_ctrl` is 0 and every lookup returns a miss.
- R2: On `cfg_init`, bitmap bits are scanned from 0 upward. Each set bit enables the window of the same number until `cfg_count` windows are enabled, and later set bits are ignored. For each enabled window i, `win_ctrl` bit i is 1 and bits [17+2i:16+2i] are 2'b11. All other `win_ctrl` bits are cleared. Windows that are not enabled keep their base and mask registers.
- R3: An enabled window i other than 4 gets base address i*`cfg_cs_size`+`cfg_base_off` and size mask 0x7FFF0000. Its attribute is 0x0E, 0x0D, 0x0B or 0x07 for windows 0, 1, 2 or 3, and 0x00 for windows 5 to 7.
- R4: An enabled window 4 gets base 0x40000000, attribute 0x1F and size mask 0x000F0000, whatever the size and offset inputs are.
- R5: An address hits window i when window i is enabled and address bits [31:16] equal base bits [31:16] in every position where mask bits [31:16] are 0.
- R6: When several windows hit, the result names the lowest-numbered one.
- R7: When no window hits, `res_hit` is 0, `res_miss` is 1, and `res_win` and `res_attr` are 0.
- R8: `cfg_shrink` sets the window 0 size mask to 0x3FFF0000, so window 0 then also compares address bit 30.
- R9: `cfg_init` first saves the current control word and the base and mask registers of windows 0 to 4. `cfg_restore` writes that snapshot back.
- R10: A lookup result appears in the cycle after `lk_req`, with `res_valid` high for that cycle only. Requests may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_init | input | 1 | Program the windows from the cfg_* inputs and save a snapshot |
| cfg_map | input | 8 | Bitmap of targets to enable |
| cfg_count | input | 4 | Maximum number of windows to enable |
| cfg_cs_size | input | 32 | Size of one chip select |
| cfg_base_off | input | 32 | Offset added to every DRAM base |
| cfg_shrink | input | 1 | Narrow window 0 to 1 GiB |
| cfg_restore | input | 1 | Write the saved snapshot back |
| win_ctrl | output | 32 | Shared window control word |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Address to look up |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address hit an enabled window |
| res_miss | output | 1 | Address hit no window |
| res_win | output | 3 | Number of the winning window |
| res_attr | output | 8 | Attribute of the winning window |

## Verification
Most configuration faults show up at the ports as soon as an affected address is looked up. A wrong base, mask or attribute gives the wrong window or the wrong attribute one cycle after the request. Overlap cases are probed so that an error in the priority order, or a shrink that has no effect, also appears at the ports. A damaged snapshot shows in `win_ctrl` on the cycle after the restore, and in the very next lookup of a restored window.

// File: rtl/addr_win_decoder.sv
module addr_win_decoder #(
  parameter int NWIN = 8,
  parameter int SNAP = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_init,
  input  logic [NWIN-1:0]           cfg_map,
  input  logic [$clog2(NWIN+1)-1:0] cfg_count,
  input  logic [31:0]               cfg_cs_size,
  input  logic [31:0]               cfg_base_off,
  input  logic                      cfg_shrink,
  input  logic                      cfg_restore,
  output logic [16+2*NWIN-1:0]      win_ctrl,
  input  logic                      lk_req,
  input  logic [31:0]               lk_addr,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic                      res_miss,
  output logic [$clog2(NWIN)-1:0]   res_win,
  output logic [7:0]                res_attr
);
  localparam int CW   = 16 + 2*NWIN;
  localparam int IW   = $clog2(NWIN);
  localparam int NW   = $clog2(NWIN+1);
  localparam int SRAM = 4;

  logic [CW-1:0] ctrl_q, snap_ctrl, nxt_ctrl;
  logic [31:0]   base_q [NWIN];
  logic [31:0]   mask_q [NWIN];
  logic [31:0]   snap_base [SNAP];
  logic [31:0]   snap_mask [SNAP];
  logic [NWIN-1:0] pick, hit_vec;
  logic [IW-1:0] win_n;
  logic          any_hit;

  function automatic logic [7:0] attr_of(input int i);
    case (i)
      0: return 8'h0E;
      1: return 8'h0D;
      2: return 8'h0B;
      3: return 8'h07;
      4: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    logic [NW:0] taken;
    taken    = '0;
    nxt_ctrl = '0;
    pick     = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (cfg_map[i] && (taken < {1'b0, cfg_count})) begin
        pick[i]            = 1'b1;
        nxt_ctrl[i]        = 1'b1;
        nxt_ctrl[16+2*i+:2] = 2'b11;
        taken              = taken + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      snap_ctrl <= '0;
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
      for (int j = 0; j < SNAP; j++) begin
        snap_base[j] <= '0;
        snap_mask[j] <= '0;
      end
    end else if (cfg_restore) begin
      ctrl_q <= snap_ctrl;
      for (int j = 0; j < SNAP; j++) begin
        base_q[j] <= snap_base[j];
        mask_q[j] <= snap_mask[j];
      end
    end else if (cfg_init) begin
      snap_ctrl <= ctrl_q;
      for (int j = 0; j < SNAP; j++) begin
        snap_base[j] <= base_q[j];
        snap_mask[j] <= mask_q[j];
      end
      ctrl_q <= nxt_ctrl;
      for (int i = 0; i < NWIN; i++) begin
        if (pick[i]) begin
          if (i == SRAM) begin
            base_q[i] <= 32'h4000_0000 | {16'h0, attr_of(i), 8'h00};
            mask_q[i] <= 32'h000F_0000;
          end else begin
            base_q[i] <= (32'(i) * cfg_cs_size + cfg_base_off) | {16'h0, attr_of(i), 8'h00};
            mask_q[i] <= 32'h7FFF_0000;
          end
        end
      end
    end else if (cfg_shrink) begin
      mask_q[0] <= 32'h3FFF_0000;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign hit_vec[g] = ctrl_q[g] &&
      (((lk_addr[31:16] ^ base_q[g][31:16]) & ~mask_q[g][31:16]) == 16'h0);
  end

  always_comb begin
    win_n = '0;
    for (int i = NWIN-1; i >= 0; i--)
      if (hit_vec[i]) win_n = IW'(i);
  end

  assign any_hit  = |hit_vec;
  assign win_ctrl = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_win   <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) begin
        res_hit  <= any_hit;
        res_miss <= !any_hit;
        res_win  <= any_hit ? win_n : '0;
        res_attr <= any_hit ? base_q[win_n][15:8] : 8'h00;
      end
    end
  end
endmodule

module addr_win_decoder_chk #(
  parameter int NWIN = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_init,
  input logic                      cfg_shrink,
  input logic                      cfg_restore,
  input logic [$clog2(NWIN+1)-1:0] cfg_count,
  input logic [16+2*NWIN-1:0]      win_ctrl,
  input logic [31:0]               mask0,
  input logic                      lk_req,
  input logic                      res_valid,
  input logic                      res_hit,
  input logic                      res_miss,
  input logic [$clog2(NWIN)-1:0]   res_win,
  input logic [7:0]                res_attr
);
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);
  a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_attr == 8'h00 && res_win == '0));
  a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_init && !cfg_restore) |=> ($countones(win_ctrl[NWIN-1:0]) <= $past(cfg_count)));
  a_r8_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shrink && !cfg_init && !cfg_restore) |=> (mask0 == 32'h3FFF_0000));
  for (genvar g = 0; g < NWIN; g++) begin : g_fld
    a_r2_access_field: assert property (@(posedge clk) disable iff (!rst_n)
      win_ctrl[g] == (win_ctrl[16+2*g+:2] == 2'b11));
  end
endmodule

bind addr_win_decoder addr_win_decoder_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_shrink(cfg_shrink),
  .cfg_restore(cfg_restore), .cfg_count(cfg_count), .win_ctrl(win_ctrl),
  .mask0(mask_q[0]), .lk_req(lk_req), .res_valid(res_valid), .res_hit(res_hit),
  .res_miss(res_miss), .res_win(res_win), .res_attr(res_attr)
);

// File: tb/addr_win_decoder_tb.sv
module addr_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_init = 1'b0, cfg_shrink = 1'b0, cfg_restore = 1'b0;
  logic [7:0]  cfg_map = '0;
  logic [3:0]  cfg_count = '0;
  logic [31:0] cfg_cs_size = '0, cfg_base_off = '0;
  logic [31:0] win_ctrl;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [7:0]  res_attr;

  int n_chk = 0, n_fail = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  addr_win_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_map(cfg_map),
    .cfg_count(cfg_count), .cfg_cs_size(cfg_cs_size), .cfg_base_off(cfg_base_off),
    .cfg_shrink(cfg_shrink), .cfg_restore(cfg_restore), .win_ctrl(win_ctrl),
    .lk_req(lk_req), .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_win(res_win), .res_attr(res_attr)
  );

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: result without request, actual valid=1 expected 0");
      end else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({res_hit, res_win, res_attr} != e || res_miss == res_hit) begin
          n_fail++;
          $display("FAIL %s: actual hit=%0b win=%0d attr=%h miss=%0b expected hit=%0b win=%0d attr=%h",
                   t, res_hit, res_win, res_attr, res_miss, e[11], e[10:8], e[7:0]);
        end
      end
    end
  end

  task automatic look(input logic [31:0] a, input logic h, input logic [2:0] w,
                      input logic [7:0] at, input string t);
    exp_q.push_back({h, w, at});
    tag_q.push_back(t);
    lk_req  = 1'b1;
    lk_addr = a;
    @(negedge clk);
    lk_req  = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic init(input logic [7:0] m, input logic [3:0] c,
                      input logic [31:0] sz, input logic [31:0] off);
    cfg_map = m; cfg_count = c; cfg_cs_size = sz; cfg_base_off = off;
    cfg_init = 1'b1;
    @(negedge clk);
    cfg_init = 1'b0;
  endtask

  task automatic pulse_shrink();
    cfg_shrink = 1'b1; @(negedge clk); cfg_shrink = 1'b0;
  endtask

  task automatic pulse_restore();
    cfg_restore = 1'b1; @(negedge clk); cfg_restore = 1'b0;
  endtask

  task automatic chk_ctrl(input logic [31:0] e, input string t);
    n_chk++;
    if (win_ctrl !== e) begin
      n_fail++;
      $display("FAIL %s: win_ctrl actual %h expected %h", t, win_ctrl, e);
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ctrl(32'h0, "R1");
    look(32'h0000_0000, 0, 0, 8'h00, "R1");
    look(32'h8000_0000, 0, 0, 8'h00, "R1");
    drain();

    init(8'h03, 4'd8, 32'h8000_0000, 32'h0);
    chk_ctrl(32'h000F_0003, "R2");
    look(32'h1234_5678, 1, 0, 8'h0E, "R3 R5");
    look(32'h9000_0000, 1, 1, 8'h0D, "R3 R5");
    drain();

    init(8'h13, 4'd3, 32'h8000_0000, 32'h0);
    chk_ctrl(32'h030F_0013, "R2");
    look(32'h4000_5000, 1, 0, 8'h0E, "R6");
    drain();
    pulse_shrink();
    look(32'h4000_5000, 1, 4, 8'h1F, "R4 R8");
    look(32'h4010_0000, 0, 0, 8'h00, "R7 R8");
    look(32'h3FFF_0000, 1, 0, 8'h0E, "R8");
    look(32'hC000_0000, 1, 1, 8'h0D, "R5");
    drain();

    init(8'h1B, 4'd2, 32'h8000_0000, 32'h0);
    chk_ctrl(32'h000F_0003, "R2");
    look(32'h4000_0000, 1, 0, 8'h0E, "R2");
    look(32'h8000_0000, 1, 1, 8'h0D, "R2");
    drain();

    init(8'h08, 4'd1, 32'h1000_0000, 32'h2000_0000);
    chk_ctrl(32'h00C0_0008, "R2");
    look(32'h5000_0000, 1, 3, 8'h07, "R3");
    look(32'h1000_0000, 1, 3, 8'h07, "R5");
    look(32'h8000_0000, 0, 0, 8'h00, "R7");
    drain();

    pulse_restore();
    chk_ctrl(32'h000F_0003, "R9");
    look(32'h8000_0000, 1, 1, 8'h0D, "R9");
    look(32'h0000_1000, 1, 0, 8'h0E, "R9");
    drain();

    init(8'h20, 4'd1, 32'h1000_0000, 32'h0);
    chk_ctrl(32'h0C00_0020, "R3");
    look(32'h0100_0000, 1, 5, 8'h00, "R3");
    drain();

    init(8'hFF, 4'd0, 32'h1000_0000, 32'h0);
    chk_ctrl(32'h0, "R2");
    look(32'h0100_0000, 0, 0, 8'h00, "R2 R7");
    drain();
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule